// File: doc/BRIEF.md
# Programmable Digital Glitch Filter

This block removes short glitches from a port of already-synchronized digital inputs. Each pin has its own enable bit. A pin whose filter is on moves its output to a new level only after the input has held that level for more filter clock ticks than the programmed width. A pin whose filter is off passes its input to its output with no register in the path.

All pins share one 5-bit width value and one filter clock choice. The filter clock is either every bus clock cycle or a slow tick. The slow tick is a one-cycle enable pulse in the bus clock domain, nominally at 1 kHz, and not a separate clock. Width and clock choice are meant to be changed only while every pin's filter is off. The block is fed from configuration state held elsewhere and has no data stream of its own, so all its pins are plain level signals with no handshake.

Top module: `pin_glitch_filter`

## Requirements
- R1: When a pin's enable bit is 0, its output equals its input in the same cycle, with no register in the path.
- R2: With clock select 0 every bus clock edge is a filter tick. With clock select 1 only edges where the slow tick input is 1 are filter ticks.
- R3: On an enabled pin, a new input level that lasts W filter ticks or fewer, where W is the width setting (0 to 31), never reaches the output.
- R4: On an enabled pin, a new level sampled on W+1 consecutive filter ticks appears at the output right after the (W+1)-th tick edge, and not earlier.
- R5: With width 0, a new level that is present on a single filter tick passes to the output after that edge.
- R6: If the input returns to the current output level before the filter accepts a change, the tick count restarts from zero. Mismatch time does not add up across separate pulses.
- R7: While a pin is disabled, its filter state follows the input and its count is cleared. When the pin is enabled again, its output starts at the current input level, and a later change needs the full W+1 ticks.
- R8: After reset, every enabled pin outputs 0 until its input has held 1 for W+1 ticks.
- R9: Pins are filtered independently. A pin whose input stays at its output level keeps its output while other pins change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NPINS | Synchronized pin inputs |
| filt_en | input | NPINS | Per-pin filter enable (1 = filtered) |
| clk_sel | input | 1 | Filter clock select: 0 = bus clock, 1 = slow tick |
| slow_tick | input | 1 | One-cycle slow clock-enable pulse |
| width | input | CW | Glitch width W; pulses of W ticks or fewer are removed |
| pin_out | output | NPINS | Filtered pin outputs |

## Verification
Two events can fall on the same edge: the count reaching the width setting, and the input going back to the output level. The sweep covers every pulse length from 1 to W+2 for each width from 0 to 6, and the lengths around the limit for width 31. This puts the input's return on the edge just before, on, and after the edge where the count is accepted. The output is sampled after every edge and compared with the rule that it rises only once more than W ticks have passed. Alongside this, a disabled neighbour pin toggles every cycle and must stay transparent, and a pin held steady must not move.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
  typedef enum logic {
    FCLK_BUS  = 1'b0,
    FCLK_SLOW = 1'b1
  } fclk_sel_e;
endpackage

// File: rtl/pgf_tick_sel.sv
module pgf_tick_sel
  import pgf_pkg::*;
(
  input  logic clk_sel,
  input  logic slow_tick,
  output logic tick
);
  // the slow source is an enable in the bus domain, never a clock
  always_comb begin
    if (fclk_sel_e'(clk_sel) == FCLK_SLOW) tick = slow_tick;
    else                                   tick = 1'b1;
  end
endmodule

// File: rtl/pgf_lane.sv
module pgf_lane #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic          en,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          dout
);
  logic          held_q;
  logic [CW-1:0] run_q;
  logic          differs;

  assign differs = din ^ held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      run_q  <= '0;
    end else if (!en) begin
      held_q <= din;
      run_q  <= '0;
    end else if (!differs) begin
      run_q  <= '0;
    end else if (tick) begin
      if (run_q >= limit) begin
        held_q <= din;
        run_q  <= '0;
      end else begin
        run_q  <= run_q + 1'b1;
      end
    end
  end

  assign dout = en ? held_q : din;

  // R2: without a tick an enabled lane never changes its level
  assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(held_q));

  // R3: a mismatch still below the limit is absorbed
  assert_short_absorbed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && differs && (run_q < limit)) |=> $stable(held_q));

  // R4: reaching the limit on a tick takes the new level
  assert_accept_at_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && differs && (run_q >= limit)) |=> (held_q == $past(din)));

  // R7: a disabled lane keeps no count
  assert_disabled_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (run_q == '0));

  // R6: agreement between input and level restarts the count
  assert_match_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !differs) |=> (run_q == '0));
endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter #(
  parameter int NPINS = 32,
  parameter int CW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] filt_en,
  input  logic             clk_sel,
  input  logic             slow_tick,
  input  logic [CW-1:0]    width,
  output logic [NPINS-1:0] pin_out
);
  logic tick;

  pgf_tick_sel u_tick (
    .clk_sel  (clk_sel),
    .slow_tick(slow_tick),
    .tick     (tick)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_lane
    pgf_lane #(.CW(CW)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_in[p]),
      .en   (filt_en[p]),
      .tick (tick),
      .limit(width),
      .dout (pin_out[p])
    );
  end
endmodule

// File: tb/pin_glitch_filter_bench.sv
module pin_glitch_filter_bench;
  localparam int NPINS = 32;
  localparam int CW    = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] pin_in = '0;
  logic [NPINS-1:0] filt_en = '0;
  logic             clk_sel = 1'b0;
  logic             slow_tick = 1'b0;
  logic [CW-1:0]    width = '0;
  logic [NPINS-1:0] pin_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pin_glitch_filter #(.NPINS(NPINS), .CW(CW)) u_pin_glitch_filter (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .filt_en(filt_en),
    .clk_sel(clk_sel), .slow_tick(slow_tick), .width(width), .pin_out(pin_out)
  );

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // pin 0 under test, pin 1 disabled and toggling, pin 2 held at 1
  task automatic pulse_run(input int w, input int len);
    width = w[CW-1:0];
    @(negedge clk);
    pin_in[0] = 1'b1;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      chk(pin_out[0], (k > w), (k > w) ? "R4" : "R3", $sformatf("w=%0d len=%0d edge=%0d", w, len, k));
      if (w == 0 && k == 1) chk(pin_out[0], 1'b1, "R5", "single tick passes");
      pin_in[1] = k[0];
      #1;
      chk(pin_out[1], pin_in[1], "R1", "disabled pin transparent");
      chk(pin_out[2], 1'b1, "R9", "steady pin unaffected");
    end
    pin_in[0] = 1'b0;
    repeat (w + 3) @(negedge clk);
    chk(pin_out[0], 1'b0, "R4", $sformatf("return low w=%0d", w));
  endtask

  initial begin
    int seen;
    bit prev_tick;
    filt_en = 32'hFFFF_FFFD;
    pin_in  = 32'h0000_0004;
    width   = 5'd3;
    repeat (3) @(negedge clk);
    chk(pin_out[0], 1'b0, "R8", "reset state pin0");
    chk(pin_out[2], 1'b0, "R8", "reset state pin2 input high");
    rst_n = 1'b1;
    @(negedge clk);
    chk(pin_out[2], 1'b0, "R8", "pin2 low after first edge");
    repeat (6) @(negedge clk);
    chk(pin_out[2], 1'b1, "R8", "pin2 high after W+1");

    for (int w = 0; w <= 6; w++)
      for (int len = 1; len <= w + 2; len++) pulse_run(w, len);
    for (int len = 30; len <= 33; len++) pulse_run(31, len);

    // R6: two pulses of W split by one matching cycle
    width = 5'd3;
    @(negedge clk);
    for (int rep = 0; rep < 2; rep++) begin
      pin_in[0] = 1'b1;
      repeat (3) begin
        @(negedge clk);
        chk(pin_out[0], 1'b0, "R6", "split pulse absorbed");
      end
      pin_in[0] = 1'b0;
      @(negedge clk);
      chk(pin_out[0], 1'b0, "R6", "gap cycle");
    end

    // R7: disable, change input, re-enable
    width = 5'd4;
    filt_en[0] = 1'b0;
    pin_in[0] = 1'b1;
    #1;
    chk(pin_out[0], 1'b1, "R1", "disabled follows input");
    @(negedge clk);
    filt_en[0] = 1'b1;
    #1;
    chk(pin_out[0], 1'b1, "R7", "re-enable starts at input level");
    @(negedge clk);
    pin_in[0] = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk(pin_out[0], (k <= 4), "R7", $sformatf("full count after re-enable k=%0d", k));
    end

    // R2: slow tick as filter clock, width 2
    do_reset();
    filt_en = 32'h0000_0001;
    pin_in = '0;
    clk_sel = 1'b1;
    width = 5'd2;
    slow_tick = 1'b0;
    @(negedge clk);
    pin_in[0] = 1'b1;
    seen = 0;
    prev_tick = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (prev_tick) seen++;
      chk(pin_out[0], (seen >= 3), "R2", $sformatf("slow tick cycle %0d ticks %0d", i, seen));
      slow_tick = ((i % 4) == 3);
      prev_tick = slow_tick;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule